// File: doc/BRIEF.md
# Character Display Register Bank

This block is the byte-wide peripheral face of a four-character LED display. A host reaches it through a 3-bit address, a pair of chip enables (one active low, one active high), active-low read and write strobes and a shared bidirectional data bus. Inside it sits one control byte and four character bytes. The display-rendering logic downstream reads the character bytes and the control byte straight from the output ports.

The strobes arrive from another timing domain. Each one passes through a synchronizer chain before it is used. A write takes effect once, on the synchronized falling edge of the write strobe. A read drives the bus for as long as the synchronized read strobe stays low. When the address MSB is high, the two low address bits pick a character slot. When it is low, the one control byte is reached at any of four aliased locations. Setting the control MSB wipes all character memory and keeps it wiped until a later control write clears that bit. A busy flag covers the settling time that the host must allow after it sets or releases the clear.

Top module: `dispreg_bank`

## Requirements
- R1: After reset, the control byte and all four character bytes are 0x00, busy is low, and a read of any location returns 0x00.
- R2: An access happens only while ce0_n is low and ce1 is high. A write strobe under any other enable combination leaves every register unchanged.
- R3: With addr[2]=1, addr[1:0] values 0 to 3 select character slots 0 to 3. Slot k appears on char_bytes[8k+7:8k]. All 8 bits are stored, including bit 7, which is the attribute flag. A read returns the stored byte.
- R4: With addr[2]=0, a write at any of the four addresses 0 to 3 updates the one control byte. A read at any of those addresses returns it.
- R5: A write commits once, on the synchronized falling edge of wr_n. A later change of the data while wr_n stays low has no effect.
- R6: data_io is driven with the addressed register only while the block is selected, rd_n is low and wr_n is high. At all other times it is released.
- R7: When rd_n and wr_n are low together, the access is a write and the bus is not driven.
- R8: A control write with bit 7 = 1 sets every character byte to 0x00. The control byte takes the written value.
- R9: While control bit 7 is 1, character writes are ignored and every character byte stays 0x00. Once a control write clears bit 7, character writes work again.
- R10: After a control write that sets bit 7, or that clears it while it was 1, busy is high for exactly BUSY_CYCLES clock cycles. Character writes, and control writes that leave bit 7 at 0, do not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 3 | Register address; MSB picks character space |
| data_io | inout | 8 | Bidirectional data bus |
| char_bytes | output | 32 | Four character bytes, slot 0 in the low byte |
| ctrl_byte | output | 8 | Control byte |
| busy | output | 1 | High during the wait window after clear is set or released |

## Verification
The bound checker watches several things on every cycle. It checks that a clear empties the character slots on the next edge and that they stay empty while the clear bit is held. It checks that each committed write lands in the register its address names, that the write event is a single pulse, and that the bus never drives while a write strobe is low. It also checks that busy only rises after a clear set or release, and that the control byte changes only under a valid select. Some things can only be shown by the bench's scenarios. These are the alias reads across all four control addresses, the exact length of the busy window, the data that arrives on the bus on reads, and the rejection of writes under either wrong chip-enable level.

// File: rtl/dispreg_pkg.sv
package dispreg_pkg;

  // Chip select: enable-low pin low and enable-high pin high.
  function automatic logic sel_ok(input logic en_lo_n, input logic en_hi);
    return (!en_lo_n) && en_hi;
  endfunction

  // Upper address bit low means the control space.
  function automatic logic in_ctrl_space(input logic addr_msb);
    return !addr_msb;
  endfunction

  // A control write touches the clear state when it sets the bit,
  // or when it clears a bit that was set.
  function automatic logic clear_edge(input logic new_bit, input logic old_bit);
    return new_bit || old_bit;
  endfunction

endpackage

// File: rtl/dispreg_strobe_sync.sv
module dispreg_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic active_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], ~strobe_n};
  end

  assign active_o = chain[STAGES-1];
endmodule

// File: rtl/dispreg_regs.sv
module dispreg_regs #(
  parameter int DATA_W    = 8,
  parameter int NUM_CHARS = 4,
  localparam int IDX_W    = $clog2(NUM_CHARS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ctrl_we,
  input  logic                          char_we,
  input  logic [IDX_W-1:0]              idx,
  input  logic [DATA_W-1:0]             din,
  output logic [NUM_CHARS*DATA_W-1:0]   char_flat,
  output logic [DATA_W-1:0]             ctrl_q
);
  localparam int MSB = DATA_W - 1;

  logic wipe;
  assign wipe = ctrl_we && din[MSB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= din;
  end

  for (genvar g = 0; g < NUM_CHARS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        char_flat[g*DATA_W +: DATA_W] <= '0;
      else if (wipe)
        char_flat[g*DATA_W +: DATA_W] <= '0;
      else if (char_we && !ctrl_q[MSB] && (idx == IDX_W'(g)))
        char_flat[g*DATA_W +: DATA_W] <= din;
    end
  end
endmodule

// File: rtl/dispreg_busy.sv
module dispreg_busy #(
  parameter int CYCLES = 200,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy_o
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           remain <= '0;
    else if (start)       remain <= CNT_W'(CYCLES);
    else if (remain != 0) remain <= remain - 1'b1;
  end

  assign busy_o = (remain != 0);
endmodule

// File: rtl/dispreg_bank.sv
module dispreg_bank
  import dispreg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_CHARS   = 4,
  parameter int BUSY_CYCLES = 200,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(NUM_CHARS),
  localparam int ADDR_W     = IDX_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ce0_n,
  input  logic                        ce1,
  input  logic                        rd_n,
  input  logic                        wr_n,
  input  logic [ADDR_W-1:0]           addr,
  inout  wire  [DATA_W-1:0]           data_io,
  output logic [NUM_CHARS*DATA_W-1:0] char_bytes,
  output logic [DATA_W-1:0]           ctrl_byte,
  output logic                        busy
);
  localparam int MSB = DATA_W - 1;

  // Named events for the checker
  logic             wr_lo, rd_lo, wr_lo_q;
  logic             selected, wr_event, ctrl_we, char_we;
  logic             clr_fire, clr_release, data_oe;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] rd_data;

  dispreg_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .active_o(wr_lo));

  dispreg_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .active_o(rd_lo));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_lo_q <= 1'b0;
    else        wr_lo_q <= wr_lo;
  end

  assign selected    = sel_ok(ce0_n, ce1);
  assign wr_event    = wr_lo && !wr_lo_q && selected;
  assign idx         = addr[IDX_W-1:0];
  assign ctrl_we     = wr_event && in_ctrl_space(addr[ADDR_W-1]);
  assign char_we     = wr_event && !in_ctrl_space(addr[ADDR_W-1]);
  assign clr_fire    = ctrl_we && data_io[MSB];
  assign clr_release = ctrl_we && !data_io[MSB] && ctrl_byte[MSB];

  dispreg_regs #(.DATA_W(DATA_W), .NUM_CHARS(NUM_CHARS)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .char_we(char_we),
    .idx(idx), .din(data_io), .char_flat(char_bytes), .ctrl_q(ctrl_byte));

  dispreg_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n),
    .start(ctrl_we && clear_edge(data_io[MSB], ctrl_byte[MSB])),
    .busy_o(busy));

  always_comb begin
    rd_data = ctrl_byte;
    if (!in_ctrl_space(addr[ADDR_W-1])) begin
      for (int i = 0; i < NUM_CHARS; i++)
        if (idx == IDX_W'(i)) rd_data = char_bytes[i*DATA_W +: DATA_W];
    end
  end

  // Write wins when both strobes are low
  assign data_oe = selected && rd_lo && !wr_lo;
  assign data_io = data_oe ? rd_data : {DATA_W{1'bz}};
endmodule

// File: rtl/dispreg_bank_chk.sv
module dispreg_bank_chk #(
  parameter int DATA_W    = 8,
  parameter int NUM_CHARS = 4,
  localparam int IDX_W    = $clog2(NUM_CHARS)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        ce0_n,
  input logic                        ce1,
  input logic [DATA_W-1:0]           data_io,
  input logic [NUM_CHARS*DATA_W-1:0] char_bytes,
  input logic [DATA_W-1:0]           ctrl_byte,
  input logic                        busy,
  input logic                        wr_event,
  input logic                        wr_lo,
  input logic                        ctrl_we,
  input logic                        char_we,
  input logic                        clr_fire,
  input logic                        clr_release,
  input logic                        data_oe,
  input logic [IDX_W-1:0]            idx
);
  localparam int MSB = DATA_W - 1;

  function automatic logic [DATA_W-1:0] slot(input logic [NUM_CHARS*DATA_W-1:0] f,
                                             input logic [IDX_W-1:0] k);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_CHARS; i++)
      if (k == IDX_W'(i)) r = f[i*DATA_W +: DATA_W];
    return r;
  endfunction

  // R8
  clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (char_bytes == '0));

  // R9
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_byte[MSB] |-> (char_bytes == '0));

  // R4
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_byte == $past(data_io)));

  // R3
  char_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_we && !ctrl_byte[MSB]) |=> (slot(char_bytes, $past(idx)) == $past(data_io)));

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_event |=> !wr_event);

  // R7
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !wr_lo);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire || clr_release) |=> busy);

  // R10
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(clr_fire || clr_release));

  // R2
  ctrl_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_byte) |-> $past(!ce0_n && ce1));
endmodule

bind dispreg_bank dispreg_bank_chk #(.DATA_W(DATA_W), .NUM_CHARS(NUM_CHARS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce0_n(ce0_n), .ce1(ce1), .data_io(data_io),
  .char_bytes(char_bytes), .ctrl_byte(ctrl_byte), .busy(busy),
  .wr_event(wr_event), .wr_lo(wr_lo), .ctrl_we(ctrl_we), .char_we(char_we),
  .clr_fire(clr_fire), .clr_release(clr_release), .data_oe(data_oe), .idx(idx));

// File: tb/dispreg_bank_bench.sv
`timescale 1ns/1ps
module dispreg_bank_bench;
  localparam int BUSY = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce0_n = 1'b1, ce1 = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0]  addr = '0;
  logic        tb_oe = 1'b0;
  logic [7:0]  tb_dout = '0;
  wire  [7:0]  data_io;
  logic [31:0] char_bytes;
  logic [7:0]  ctrl_byte;
  logic        busy;

  int total = 0, bad = 0;
  logic strobe = 1'b0;
  logic finished = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  assign data_io = tb_oe ? tb_dout : 8'bz;

  always #2.5 clk = ~clk;

  dispreg_bank #(.BUSY_CYCLES(BUSY)) u_dispreg_bank (
    .clk(clk), .rst_n(rst_n), .ce0_n(ce0_n), .ce1(ce1), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .data_io(data_io), .char_bytes(char_bytes),
    .ctrl_byte(ctrl_byte), .busy(busy));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // Scoreboard monitor: compares bus reads against queued expectations
  always @(negedge clk) begin
    if (strobe && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {24'h0, data_io}, {24'h0, e});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d,
                    input logic en_lo_n = 1'b0, input logic en_hi = 1'b1,
                    input logic with_rd = 1'b0);
    @(posedge clk); #1;
    addr = a; ce0_n = en_lo_n; ce1 = en_hi; tb_dout = d; tb_oe = 1'b1;
    wr_n = 1'b0; rd_n = ~with_rd;
    tick(4);
    wr_n = 1'b1; rd_n = 1'b1;
    tick(3);
    tb_oe = 1'b0; ce0_n = 1'b1; ce1 = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    addr = a; ce0_n = 1'b0; ce1 = 1'b1; rd_n = 1'b0;
    exp_q.push_back(e); tag_q.push_back(tag);
    tick(3);
    strobe = 1'b1;
    tick(1);
    strobe = 1'b0; rd_n = 1'b1;
    tick(3);
    ce0_n = 1'b1; ce1 = 1'b0;
  endtask

  task automatic busy_len(input logic [2:0] a, input logic [7:0] d, output int n);
    int cnt;
    cnt = 0;
    fork
      wr(a, d);
      begin
        repeat (3 * BUSY) begin @(negedge clk); if (busy) cnt++; end
      end
    join
    n = cnt;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    @(negedge clk);
    chk("R1 chars", char_bytes, 32'h0);
    chk("R1 ctrl", {24'h0, ctrl_byte}, 32'h0);
    chk("R1 busy", {31'h0, busy}, 32'h0);
    rd(3'd0, 8'h00, "R1 read ctrl");
    rd(3'd6, 8'h00, "R1 read slot2");

    // R4 aliasing
    wr(3'd0, 8'h03);
    @(negedge clk); chk("R4 ctrl via 0", {24'h0, ctrl_byte}, 32'h03);
    rd(3'd1, 8'h03, "R4 read alias1");
    rd(3'd2, 8'h03, "R4 read alias2");
    rd(3'd3, 8'h03, "R4 read alias3");
    wr(3'd3, 8'h17);
    rd(3'd0, 8'h17, "R4 write alias3 read 0");

    // R3 slots with attribute bit
    wr(3'd7, 8'h53);
    wr(3'd6, 8'h54);
    wr(3'd5, 8'hCF);
    wr(3'd4, 8'h50);
    @(negedge clk); chk("R3 slot map", char_bytes, 32'h5354CF50);
    rd(3'd5, 8'hCF, "R3 read slot1 attr");
    rd(3'd7, 8'h53, "R3 read slot3");

    // R2 wrong enables
    wr(3'd4, 8'h11, 1'b1, 1'b1);
    wr(3'd4, 8'h22, 1'b0, 1'b0);
    wr(3'd0, 8'h44, 1'b1, 1'b0);
    @(negedge clk); chk("R2 chars kept", char_bytes, 32'h5354CF50);
    chk("R2 ctrl kept", {24'h0, ctrl_byte}, 32'h17);

    // R6 release when not selected: bench holds bus at 0
    @(posedge clk); #1;
    addr = 3'd5; ce0_n = 1'b1; ce1 = 1'b1; rd_n = 1'b0; tb_oe = 1'b1; tb_dout = 8'h00;
    tick(4);
    @(negedge clk); chk("R6 released when deselected", {24'h0, data_io}, 32'h0);
    @(posedge clk); #1; rd_n = 1'b1; tb_oe = 1'b0;
    tick(3);

    // R5 data change while wr held low
    @(posedge clk); #1;
    addr = 3'd6; ce0_n = 1'b0; ce1 = 1'b1; tb_dout = 8'h61; tb_oe = 1'b1; wr_n = 1'b0;
    tick(5);
    tb_dout = 8'h7A;
    tick(3);
    wr_n = 1'b1;
    tick(3);
    tb_oe = 1'b0; ce0_n = 1'b1; ce1 = 1'b0;
    @(negedge clk); chk("R5 single commit", {24'h0, char_bytes[23:16]}, 32'h61);

    // R7 both strobes low is a write
    wr(3'd5, 8'h41, 1'b0, 1'b1, 1'b1);
    @(negedge clk); chk("R7 both low writes", {24'h0, char_bytes[15:8]}, 32'h41);

    // R10 no busy on ordinary writes
    busy_len(3'd4, 8'h30, n);
    chk("R10 char write no busy", n, 0);
    busy_len(3'd1, 8'h1F, n);
    chk("R10 ctrl write no busy", n, 0);

    // R8 clear
    busy_len(3'd2, 8'h80, n);
    chk("R10 busy after set", n, BUSY);
    chk("R8 chars wiped", char_bytes, 32'h0);
    chk("R8 ctrl value", {24'h0, ctrl_byte}, 32'h80);

    // R9 writes ignored while clear held
    wr(3'd4, 8'h33);
    wr(3'd7, 8'h34);
    @(negedge clk); chk("R9 ignored while clear", char_bytes, 32'h0);
    rd(3'd4, 8'h00, "R9 read slot0 while clear");

    // release
    busy_len(3'd0, 8'h03, n);
    chk("R10 busy after release", n, BUSY);
    wr(3'd4, 8'h35);
    @(negedge clk); chk("R9 write after release", {24'h0, char_bytes[7:0]}, 32'h35);
    rd(3'd4, 8'h35, "R6 read after release");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule